// File: doc/BRIEF.md
# TDM Audio Frame Serial Transmitter

This block is the transmit side of a multi-channel audio serial link, running as clock master. It works from a system clock plus a strobe, `half_en`, that fires once per half bit period. From these it builds the bit clock `sclk`, a frame sync, and a serial data line. The link can carry anything from plain stereo I2S to wide TDM frames.

A frame has one phase or two. Each phase sets its own channel count, its own slot width and its own sample width. The frame length, the sync pulse width, the sync polarity, the sclk edge that launches data, the sample justification inside a slot and a data lag of up to two bits can all be set independently. Samples arrive in parallel over a valid/ready handshake, and one sample is taken at the first bit of every slot. If no sample is offered at that point, the slot is sent as zeros and an underrun pulse is raised.

Configuration inputs are sampled only at a frame boundary, or at any time while the block is disabled.

Top module: `tdm_tx`

## Requirements
- R1: While `enable` is high, `sclk` toggles on every cycle with `half_en` high. While `enable` is low, `sclk` is held low.
- R2: `sdata` and `fsync` change only on the launch edge of `sclk`. With `cfg_tx_rise`=1 the launch edge is the rising edge; with `cfg_tx_rise`=0 it is the falling edge. The first launch edge after enabling is bit 0 of the first frame.
- R3: A frame lasts `cfg_period`+1 bit periods. `fsync` is active for the first `cfg_fs_width` bits of each frame. Active means high when `cfg_fs_low`=0 and low when `cfg_fs_low`=1.
- R4: In a single-phase frame (`cfg_dual`=0) there are `cfg_nch0`+1 slots, each with the slot width coded by `cfg_slot0`, sent back to back. Samples go out MSB first. Width codes are 0=8, 1=12, 2=16, 3=20, 4=24, 5=32 bits; codes 6 and 7 mean 32 bits.
- R5: With `cfg_dual`=1, the phase-0 slots are followed directly by `cfg_nch1`+1 slots that use the phase-1 slot and sample widths.
- R6: When `cfg_right_just`=0, the sample bits start at the first bit of the slot, and the remaining bits of the slot are 0.
- R7: When `cfg_right_just`=1, the slot starts with slot width minus sample width zero bits, and the sample ends at the last bit of the slot. If the sample width is larger than the slot width, it is cut down to the slot width, and the low bits of `s_data` are sent.
- R8: Slot data begins `cfg_delay` bit periods after the frame start. The bits ahead of it are 0. A delay code of 3 acts as 2.
- R9: `s_ready` is high for exactly the one cycle in which the first bit of a slot is launched. A sample is taken in that cycle if `s_valid` is high.
- R10: If `s_valid` is low when a slot starts, that whole slot is sent as zeros, and `underrun` is high for one cycle in the next cycle.
- R11: Bits after the last slot are 0, and a slot that runs past the end of the frame is cut off. While `enable` is low, `sdata` and `underrun` are 0, `sdata_oe` is 0, and `fsync` sits at its inactive level. `sdata_oe` rises one cycle after `enable`.
- R12: Configuration changes made in the middle of a frame take effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run enable |
| half_en | input | 1 | Half bit period strobe |
| cfg_dual | input | 1 | 0 single phase, 1 two phases |
| cfg_nch0 | input | CH_W | Phase 0 channel count minus one |
| cfg_nch1 | input | CH_W | Phase 1 channel count minus one |
| cfg_slot0 | input | 3 | Phase 0 slot width code |
| cfg_slot1 | input | 3 | Phase 1 slot width code |
| cfg_samp0 | input | 3 | Phase 0 sample width code |
| cfg_samp1 | input | 3 | Phase 1 sample width code |
| cfg_delay | input | 2 | Data lag in bits |
| cfg_period | input | PER_W | Frame length minus one, in bits |
| cfg_fs_width | input | PER_W | Sync active length in bits |
| cfg_fs_low | input | 1 | Sync active low |
| cfg_tx_rise | input | 1 | Launch data on rising sclk |
| cfg_right_just | input | 1 | Right justification |
| s_data | input | 32 | Sample |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample taken this cycle |
| sclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| sdata_oe | output | 1 | Data output enable |
| underrun | output | 1 | Missing sample pulse |

## Verification
The assertions assume that `half_en` is a strobe that never fires on two cycles in a row. They also assume that reset is held for at least two cycles, so every `$past` value is a value that reset itself set. The bench drives `half_en` on every other cycle. It holds reset for three cycles, and it changes configuration only in the middle of the per-cycle loop, where the design samples it at a frame boundary exactly as the reference model does. Underrun is provoked on purpose by withdrawing `s_valid` on every third slot.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int SMP_W = 32;
    localparam int BIT_W = 6;

    typedef enum logic [2:0] {
        WC8  = 3'd0,
        WC12 = 3'd1,
        WC16 = 3'd2,
        WC20 = 3'd3,
        WC24 = 3'd4,
        WC32 = 3'd5
    } wcode_e;

    typedef struct packed {
        logic       dual;
        logic       fs_low;
        logic       tx_rise;
        logic       right_just;
        logic [1:0] delay;
    } mode_t;

    typedef struct packed {
        logic [BIT_W-1:0] slot_w;
        logic [BIT_W-1:0] samp_w;
    } phase_fmt_t;

    function automatic logic [BIT_W-1:0] wcode_bits(input logic [2:0] c);
        case (c)
            WC8:     return 6'd8;
            WC12:    return 6'd12;
            WC16:    return 6'd16;
            WC20:    return 6'd20;
            WC24:    return 6'd24;
            default: return 6'd32;
        endcase
    endfunction

    function automatic phase_fmt_t decode_fmt(input logic [2:0] slot_c, input logic [2:0] samp_c);
        phase_fmt_t f;
        f.slot_w = wcode_bits(slot_c);
        f.samp_w = wcode_bits(samp_c);
        if (f.samp_w > f.slot_w) f.samp_w = f.slot_w;
        return f;
    endfunction

    function automatic logic [1:0] eff_delay(input logic [1:0] d);
        return (d == 2'd3) ? 2'd2 : d;
    endfunction

endpackage

// File: rtl/tdm_tx_clkgen.sv
module tdm_tx_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic half_en,
    input  logic tx_rise,
    output logic sclk,
    output logic launch
);

    // the toggle about to happen is the launch edge when it goes toward tx_rise
    always_comb launch = enable && half_en && (sclk == !tx_rise);

    always_ff @(posedge clk) begin
        if (rst || !enable) sclk <= 1'b0;
        else if (half_en)   sclk <= !sclk;
    end

endmodule

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
    import tdm_tx_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int PER_W = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       enable,
    input  logic                       launch,
    input  mode_t                      cfg_mode,
    input  logic [1:0][CH_W-1:0]       cfg_nch,
    input  phase_fmt_t [1:0]           cfg_fmt,
    input  logic [PER_W-1:0]           cfg_period,
    input  logic [PER_W-1:0]           cfg_fs_width,
    output mode_t                      cur_mode,
    output phase_fmt_t                 cur_fmt,
    output logic [BIT_W-1:0]           bit_idx,
    output logic                       data_on,
    output logic                       slot_start,
    output logic                       fs_act
);

    mode_t                mode_q;
    logic [1:0][CH_W-1:0] nch_q;
    phase_fmt_t [1:0]     fmt_q;
    logic [PER_W-1:0]     period_q;
    logic [PER_W-1:0]     fsw_q;
    logic [PER_W-1:0]     pos_q;
    logic                 phase_q;
    logic [CH_W-1:0]      chan_q;
    logic [BIT_W-1:0]     k_q;
    logic                 done_q;

    assign cur_mode   = mode_q;
    assign cur_fmt    = fmt_q[phase_q];
    assign bit_idx    = k_q;
    assign data_on    = !done_q && (pos_q >= PER_W'(eff_delay(mode_q.delay)));
    assign slot_start = data_on && (k_q == '0);
    assign fs_act     = pos_q < fsw_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            mode_q   <= cfg_mode;
            nch_q    <= cfg_nch;
            fmt_q    <= cfg_fmt;
            period_q <= cfg_period;
            fsw_q    <= cfg_fs_width;
            pos_q    <= '0;
            phase_q  <= 1'b0;
            chan_q   <= '0;
            k_q      <= '0;
            done_q   <= 1'b0;
        end else if (launch) begin
            if (pos_q == period_q) begin
                // frame boundary: new configuration and fresh cursor
                mode_q   <= cfg_mode;
                nch_q    <= cfg_nch;
                fmt_q    <= cfg_fmt;
                period_q <= cfg_period;
                fsw_q    <= cfg_fs_width;
                pos_q    <= '0;
                phase_q  <= 1'b0;
                chan_q   <= '0;
                k_q      <= '0;
                done_q   <= 1'b0;
            end else begin
                pos_q <= pos_q + PER_W'(1);
                if (data_on) begin
                    if (k_q == cur_fmt.slot_w - 6'd1) begin
                        k_q <= '0;
                        if (chan_q == nch_q[phase_q]) begin
                            chan_q <= '0;
                            if (!mode_q.dual || phase_q) done_q  <= 1'b1;
                            else                         phase_q <= 1'b1;
                        end else begin
                            chan_q <= chan_q + CH_W'(1);
                        end
                    end else begin
                        k_q <= k_q + 6'd1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tdm_tx_bitsel.sv
module tdm_tx_bitsel
    import tdm_tx_pkg::*;
(
    input  logic [SMP_W-1:0] word,
    input  logic [BIT_W-1:0] k,
    input  phase_fmt_t       fmt,
    input  logic             right_just,
    output logic             bit_o
);

    logic [BIT_W-1:0] pad;
    logic [BIT_W-1:0] off;
    logic [4:0]       idx;

    always_comb begin
        pad   = right_just ? (fmt.slot_w - fmt.samp_w) : '0;
        off   = k - pad;
        idx   = 5'(fmt.samp_w - 6'd1 - off);
        bit_o = 1'b0;
        if ((k >= pad) && (off < fmt.samp_w)) bit_o = word[idx];
    end

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_tx_pkg::*;
#(
    parameter int CH_W  = 4,
    parameter int PER_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             half_en,
    input  logic             cfg_dual,
    input  logic [CH_W-1:0]  cfg_nch0,
    input  logic [CH_W-1:0]  cfg_nch1,
    input  logic [2:0]       cfg_slot0,
    input  logic [2:0]       cfg_slot1,
    input  logic [2:0]       cfg_samp0,
    input  logic [2:0]       cfg_samp1,
    input  logic [1:0]       cfg_delay,
    input  logic [PER_W-1:0] cfg_period,
    input  logic [PER_W-1:0] cfg_fs_width,
    input  logic             cfg_fs_low,
    input  logic             cfg_tx_rise,
    input  logic             cfg_right_just,
    input  logic [SMP_W-1:0] s_data,
    input  logic             s_valid,
    output logic             s_ready,
    output logic             sclk,
    output logic             fsync,
    output logic             sdata,
    output logic             sdata_oe,
    output logic             underrun
);

    mode_t                mode_in;
    logic [1:0][2:0]      slot_c;
    logic [1:0][2:0]      samp_c;
    logic [1:0][CH_W-1:0] nch_in;
    phase_fmt_t [1:0]     fmt_in;

    assign mode_in = '{dual: cfg_dual, fs_low: cfg_fs_low, tx_rise: cfg_tx_rise,
                       right_just: cfg_right_just, delay: cfg_delay};
    assign slot_c  = {cfg_slot1, cfg_slot0};
    assign samp_c  = {cfg_samp1, cfg_samp0};
    assign nch_in  = {cfg_nch1, cfg_nch0};

    for (genvar p = 0; p < 2; p++) begin : g_phase
        assign fmt_in[p] = decode_fmt(slot_c[p], samp_c[p]);
    end

    mode_t            cur_mode;
    phase_fmt_t       cur_fmt;
    logic [BIT_W-1:0] bit_idx;
    logic             data_on;
    logic             slot_start;
    logic             fs_act;
    logic             launch;
    logic             bit_val;
    logic [SMP_W-1:0] word_q;
    logic [SMP_W-1:0] word_now;

    tdm_tx_clkgen u_clk (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .half_en (half_en),
        .tx_rise (cur_mode.tx_rise),
        .sclk    (sclk),
        .launch  (launch)
    );

    tdm_tx_seq #(.CH_W(CH_W), .PER_W(PER_W)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .launch       (launch),
        .cfg_mode     (mode_in),
        .cfg_nch      (nch_in),
        .cfg_fmt      (fmt_in),
        .cfg_period   (cfg_period),
        .cfg_fs_width (cfg_fs_width),
        .cur_mode     (cur_mode),
        .cur_fmt      (cur_fmt),
        .bit_idx      (bit_idx),
        .data_on      (data_on),
        .slot_start   (slot_start),
        .fs_act       (fs_act)
    );

    assign word_now = slot_start ? (s_valid ? s_data : '0) : word_q;
    assign s_ready  = launch && slot_start;

    tdm_tx_bitsel u_sel (
        .word       (word_now),
        .k          (bit_idx),
        .fmt        (cur_fmt),
        .right_just (cur_mode.right_just),
        .bit_o      (bit_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sdata    <= 1'b0;
            fsync    <= 1'b0;
            sdata_oe <= 1'b0;
            underrun <= 1'b0;
            word_q   <= '0;
        end else if (!enable) begin
            sdata    <= 1'b0;
            fsync    <= cfg_fs_low;
            sdata_oe <= 1'b0;
            underrun <= 1'b0;
        end else begin
            sdata_oe <= 1'b1;
            underrun <= s_ready && !s_valid;
            if (launch) begin
                sdata <= data_on && bit_val;
                fsync <= fs_act ^ cur_mode.fs_low;
                if (slot_start) word_q <= word_now;
            end
        end
    end

endmodule

// File: rtl/tdm_tx_chk.sv
module tdm_tx_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic half_en,
    input logic s_valid,
    input logic s_ready,
    input logic sclk,
    input logic fsync,
    input logic sdata,
    input logic sdata_oe,
    input logic underrun
);

    p_ready_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (enable && half_en));

    p_underrun_cause_r10: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $past(s_ready && !s_valid));

    p_underrun_raised_r10: assert property (@(posedge clk) disable iff (rst)
        (s_ready && !s_valid) |=> underrun);

    p_idle_off_r11: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!sclk && !sdata && !sdata_oe && !underrun));

    p_oe_on_r11: assert property (@(posedge clk) disable iff (rst)
        enable |=> sdata_oe);

    p_change_on_edge_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && $stable(sclk)) |-> ($stable(sdata) && $stable(fsync)));

endmodule

bind tdm_tx tdm_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .half_en  (half_en),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .sclk     (sclk),
    .fsync    (fsync),
    .sdata    (sdata),
    .sdata_oe (sdata_oe),
    .underrun (underrun)
);

// File: tb/tdm_tx_tb.sv
`timescale 1ns/1ps
module tdm_tx_tb;

    logic clk = 1'b0;
    always #2 clk = !clk;

    logic        c_rst = 1'b1, c_en = 1'b0, c_half = 1'b0;
    logic        c_dual = 1'b0;
    logic [3:0]  c_nch0 = 4'd1, c_nch1 = 4'd0;
    logic [2:0]  c_slot0 = 3'd2, c_slot1 = 3'd2, c_samp0 = 3'd2, c_samp1 = 3'd2;
    logic [1:0]  c_delay = 2'd1;
    logic [8:0]  c_per = 9'd31, c_fsw = 9'd16;
    logic        c_fslow = 1'b1, c_txr = 1'b0, c_rj = 1'b0;
    logic [31:0] c_data = '0;
    logic        c_valid = 1'b0;

    wire s_ready, sclk, fsync, sdata, sdata_oe, underrun;

    tdm_tx u_dut (
        .clk(clk), .rst(c_rst), .enable(c_en), .half_en(c_half),
        .cfg_dual(c_dual), .cfg_nch0(c_nch0), .cfg_nch1(c_nch1),
        .cfg_slot0(c_slot0), .cfg_slot1(c_slot1), .cfg_samp0(c_samp0), .cfg_samp1(c_samp1),
        .cfg_delay(c_delay), .cfg_period(c_per), .cfg_fs_width(c_fsw),
        .cfg_fs_low(c_fslow), .cfg_tx_rise(c_txr), .cfg_right_just(c_rj),
        .s_data(c_data), .s_valid(c_valid), .s_ready(s_ready),
        .sclk(sclk), .fsync(fsync), .sdata(sdata), .sdata_oe(sdata_oe), .underrun(underrun)
    );

    int checks = 0, errors = 0;
    string tag_sd = "R4";
    bit starve = 0;
    int slot_ct = 0, sent_ct = 0;

    // reference model state
    bit m_sclk, m_sd, m_fs, m_oe, m_und;
    int m_pos;
    bit [31:0] m_word;
    bit m_dual, m_fslow, m_txr, m_rj;
    int m_nch[2], m_slotc[2], m_sampc[2], m_delay, m_per, m_fsw;
    int fb_idx[512];
    bit fb_start[512];

    function automatic int wbits(int c);
        case (c)
            0: return 8;  1: return 12; 2: return 16;
            3: return 20; 4: return 24; default: return 32;
        endcase
    endfunction

    function automatic bit [31:0] sample(int n);
        return (32'h9E3779B9 * (n + 1)) ^ 32'h5A5A0F0F;
    endfunction

    task automatic build();
        int q;
        for (int p = 0; p < 512; p++) begin fb_idx[p] = -1; fb_start[p] = 0; end
        q = (m_delay == 3) ? 2 : m_delay;
        for (int ph = 0; ph < (m_dual ? 2 : 1); ph++) begin
            int sw, smp, pad;
            sw  = wbits(m_slotc[ph]);
            smp = wbits(m_sampc[ph]);
            if (smp > sw) smp = sw;
            pad = m_rj ? sw - smp : 0;
            for (int ch = 0; ch <= m_nch[ph]; ch++) begin
                for (int k = 0; k < sw; k++) begin
                    if (q + k <= m_per) begin
                        if (k == 0) fb_start[q + k] = 1;
                        if (k >= pad && k - pad < smp) fb_idx[q + k] = smp - 1 - (k - pad);
                    end
                end
                q += sw;
            end
        end
    endtask

    task automatic latch_cfg();
        m_dual = c_dual; m_nch[0] = c_nch0; m_nch[1] = c_nch1;
        m_slotc[0] = c_slot0; m_slotc[1] = c_slot1;
        m_sampc[0] = c_samp0; m_sampc[1] = c_samp1;
        m_delay = c_delay; m_per = c_per; m_fsw = c_fsw;
        m_fslow = c_fslow; m_txr = c_txr; m_rj = c_rj;
        build();
    endtask

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", what, act, exp, $time);
        end
    endtask

    task automatic step();
        bit launch, st, exp_rdy;
        @(negedge clk);
        c_half  = !c_half;
        c_valid = !(starve && (slot_ct % 3 == 2));
        c_data  = sample(sent_ct);
        launch  = c_en && !c_rst && c_half && (m_sclk == !m_txr);
        st      = launch && fb_start[m_pos];
        exp_rdy = st;
        #1;
        if (!c_rst) chk("R9 s_ready", s_ready, exp_rdy);
        @(posedge clk);
        #1;
        if (c_rst || !c_en) begin
            m_sclk = 0; m_pos = 0; m_sd = 0; m_oe = 0; m_und = 0;
            m_fs = c_rst ? 1'b0 : c_fslow;
            latch_cfg();
        end else begin
            m_oe = 1;
            m_und = st && !c_valid;
            if (c_half) m_sclk = !m_sclk;
            if (launch) begin
                if (st) begin
                    m_word = c_valid ? c_data : 32'd0;
                    if (c_valid) sent_ct++;
                    slot_ct++;
                end
                m_sd = (fb_idx[m_pos] >= 0) ? m_word[fb_idx[m_pos]] : 1'b0;
                m_fs = (m_pos < m_fsw) ? !m_fslow : m_fslow;
                if (m_pos == m_per) begin m_pos = 0; latch_cfg(); end
                else m_pos++;
            end
        end
        if (!c_rst) begin
            chk("R1 sclk", sclk, m_sclk);
            chk("R3 fsync", fsync, m_fs);
            chk({tag_sd, " sdata"}, sdata, m_sd);
            chk("R11 sdata_oe", sdata_oe, m_oe);
            chk("R10 underrun", underrun, m_und);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic pause();
        c_en = 1'b0;
        tag_sd = "R11";
        run(6);
        c_en = 1'b1;
    endtask

    initial begin
        run(3);
        c_rst = 1'b0;
        step();
        // reset state, R11
        chk("R11 reset sdata", sdata, 1'b0);
        chk("R11 reset oe", sdata_oe, 1'b0);
        chk("R1 reset sclk", sclk, 1'b0);

        // A: stereo-like single phase, delay 1, active-low sync, falling launch
        c_en = 1'b1; tag_sd = "R4 R2";
        run(420);

        // B: two phases, right justified, rising launch, tail zeros
        pause();
        c_dual = 1; c_nch0 = 4'd1; c_slot0 = 3'd5; c_samp0 = 3'd4; c_rj = 1;
        c_nch1 = 4'd0; c_slot1 = 3'd2; c_samp1 = 3'd1; c_delay = 0;
        c_per = 9'd95; c_fsw = 9'd1; c_fslow = 0; c_txr = 1;
        tag_sd = "R5 R7 R2";
        run(1250);

        // C: left justified short samples, delay 2 then code 3 mid frame
        pause();
        c_dual = 0; c_nch0 = 4'd2; c_slot0 = 3'd4; c_samp0 = 3'd3; c_rj = 0;
        c_delay = 2; c_per = 9'd73; c_fsw = 9'd37; c_fslow = 0; c_txr = 0;
        tag_sd = "R6 R8";
        run(640);
        c_delay = 3;
        run(640);

        // D: starved slots
        pause();
        c_nch0 = 4'd1; c_slot0 = 3'd2; c_samp0 = 3'd2; c_delay = 1;
        c_per = 9'd31; c_fsw = 9'd16; c_fslow = 1;
        starve = 1; tag_sd = "R10";
        run(600);
        starve = 0;

        // E: mid-frame configuration change
        pause();
        c_nch0 = 4'd3; c_slot0 = 3'd0; c_samp0 = 3'd0; c_delay = 0; c_per = 9'd40; c_fsw = 9'd4;
        tag_sd = "R12";
        run(70);
        c_nch0 = 4'd1; c_slot0 = 3'd3; c_samp0 = 3'd3; c_per = 9'd50; c_fsw = 9'd20; c_txr = 1;
        run(500);

        // F: sample wider than slot, both justifications
        pause();
        c_nch0 = 4'd1; c_slot0 = 3'd0; c_samp0 = 3'd5; c_delay = 1; c_per = 9'd17;
        c_rj = 1; tag_sd = "R7";
        run(300);
        c_rj = 0;
        run(300);

        // G: frame shorter than slots, truncation
        pause();
        c_nch0 = 4'd1; c_slot0 = 3'd2; c_samp0 = 3'd2; c_delay = 0; c_per = 9'd20;
        tag_sd = "R11";
        run(300);

        pause();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule